// File: doc/BRIEF.md
# Asynchronous Memory Write Strobe Controller with Ready Wait

This block runs a single write access toward an external asynchronous device such as an SRAM or a peripheral with a parallel bus. A request carries an address, a data byte and three timing counts: a setup count, a write-strobe pulse count and a hold count. The controller drives an active-low chip select across the whole access. It drives an active-low write strobe only during the pulse. It holds the address and data lines steady for the full access and raises a one-cycle done flag at the end.

The external device can lengthen the access through an active-low wait line. That line passes through a two-register synchronizer. The controller looks at it only on the final cycle of the write pulse, and only when the 2-bit wait-mode field of the request is `2'b11` (ready mode). If wait is asserted at that moment, both strobes stay active until the synchronized wait releases, and then the hold phase runs. A wait level seen at any other time does not change the access length, and every other mode value ignores the line.

A new request is taken only while the controller is idle. It is typically placed behind a bus-side decoder that presents one request at a time and waits for done.

Top module: `asram_wr_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, mem_cs_n and mem_we_n are 1, and done and busy are 0.
- R2: With no wait extension, mem_cs_n is low for exactly S+P+H consecutive cycles starting the cycle after a request is accepted, and mem_we_n is low for exactly P cycles beginning after the S setup cycles. Here S, P and H are cfg_setup, cfg_pulse and cfg_hold.
- R3: A setup or hold count of 0 removes that phase entirely, and a pulse count of 0 behaves as a pulse count of 1.
- R4: In ready mode (cfg_wait_mode == 2'b11), the wait sample taken on the last pulse cycle reflects mem_wait_n as clocked two edges earlier. If that sample is low, the strobe stays low until the synchronized wait is high. Counting edges from acceptance (edge 0), when mem_wait_n is low up to edge Er-1 and high from edge Er, the write strobe is low for max(P, Er+2-S) cycles.
- R5: In ready mode, a wait that releases before the sample point, or that asserts after it, leaves the access at its unextended length.
- R6: For any cfg_wait_mode other than 2'b11, mem_wait_n has no effect on the access length.
- R7: done is high for exactly one cycle, the cycle after the last hold cycle, with both strobes high. busy is high from the cycle after acceptance through that done cycle and low afterwards.
- R8: mem_addr and mem_data equal the accepted request values on every cycle mem_cs_n is low, and do not change during the access.
- R9: req_valid asserted while busy is ignored: it neither restarts nor alters the access in progress, and produces no extra access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | AW | Address for the write |
| req_data | input | DW | Data byte for the write |
| cfg_setup | input | CW | Setup cycles before the write strobe |
| cfg_pulse | input | CW | Write strobe cycles (0 treated as 1) |
| cfg_hold | input | CW | Hold cycles after the strobe |
| cfg_wait_mode | input | 2 | Wait handling; 2'b11 selects ready mode |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion flag |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | AW | Address lines |
| mem_data | output | DW | Data lines |
| mem_wait_n | input | 1 | Active-low wait from the device, asynchronous |

## Verification
The close call is between the pulse counter reaching its last cycle and the synchronized wait sample changing. Ending the pulse and starting a suspension can fall in the same cycle, and that cycle decides whether the strobe is extended. The bench releases the wait line at every edge position from before acceptance to well past the pulse, across small setup, pulse and hold counts. It then compares the measured strobe width against max(P, Er+2-S) computed from the release edge. It also asserts wait exactly one edge after the last ignored position, and repeats the sweep with the mode set to a non-ready value, where the width must stay at P.

// File: rtl/asram_wr_pkg.sv
package asram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_WAIT  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  localparam logic [1:0] WMODE_READY = 2'b11;

endpackage

// File: rtl/asram_wait_sync.sv
module asram_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_n_async,
  output logic wait_active
);

  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= wait_n_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], wait_n_async};
      end
    end
  endgenerate

  // internal polarity is active high
  assign wait_active = ~sr[STAGES-1];

endmodule

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/asram_wr_fsm.sv
module asram_wr_fsm
  import asram_wr_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_hold,
  input  logic [1:0]    cfg_wait_mode,
  input  logic          wait_active,
  input  logic          cnt_zero,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          accept,
  output logic          cs_n_q,
  output logic          we_n_q,
  output logic          done_q,
  output logic          busy_q
);

  phase_e        state, nxt;
  logic [CW-1:0] lat_pulse;
  logic [CW-1:0] lat_hold;
  logic          lat_ready;
  logic [CW-1:0] pulse_eff;

  assign pulse_eff = (cfg_pulse == '0) ? CW'(1) : cfg_pulse;

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          if (cfg_setup != '0) begin
            nxt     = PH_SETUP;
            cnt_val = cfg_setup - 1'b1;
          end else begin
            nxt     = PH_PULSE;
            cnt_val = pulse_eff - 1'b1;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          nxt      = PH_PULSE;
          cnt_load = 1'b1;
          cnt_val  = lat_pulse - 1'b1;
        end
      end
      PH_PULSE, PH_WAIT: begin
        if ((state == PH_PULSE && cnt_zero && lat_ready && wait_active) ||
            (state == PH_WAIT && wait_active)) begin
          nxt = PH_WAIT;
        end else if (cnt_zero) begin
          if (lat_hold != '0) begin
            nxt      = PH_HOLD;
            cnt_load = 1'b1;
            cnt_val  = lat_hold - 1'b1;
          end else begin
            nxt = PH_DONE;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_zero) nxt = PH_DONE;
      end
      PH_DONE: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      lat_pulse <= CW'(1);
      lat_hold  <= '0;
      lat_ready <= 1'b0;
      cs_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      done_q    <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      state  <= nxt;
      cs_n_q <= !(nxt inside {PH_SETUP, PH_PULSE, PH_WAIT, PH_HOLD});
      we_n_q <= !(nxt inside {PH_PULSE, PH_WAIT});
      done_q <= (nxt == PH_DONE);
      busy_q <= (nxt != PH_IDLE);
      if (accept) begin
        lat_pulse <= pulse_eff;
        lat_hold  <= cfg_hold;
        lat_ready <= (cfg_wait_mode == WMODE_READY);
      end
    end
  end

endmodule

// File: rtl/asram_wr_ctrl.sv
module asram_wr_ctrl #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_hold,
  input  logic [1:0]    cfg_wait_mode,
  output logic          busy,
  output logic          done,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_wait_n
);

  logic          wait_active;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic          accept;

  asram_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .wait_n_async (mem_wait_n),
    .wait_active  (wait_active)
  );

  asram_phase_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_wr_fsm #(.CW(CW)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .cfg_setup     (cfg_setup),
    .cfg_pulse     (cfg_pulse),
    .cfg_hold      (cfg_hold),
    .cfg_wait_mode (cfg_wait_mode),
    .wait_active   (wait_active),
    .cnt_zero      (cnt_zero),
    .cnt_load      (cnt_load),
    .cnt_val       (cnt_val),
    .accept        (accept),
    .cs_n_q        (mem_cs_n),
    .we_n_q        (mem_we_n),
    .done_q        (done),
    .busy_q        (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_data <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_data <= req_data;
    end
  end

endmodule

// File: rtl/asram_wr_chk.sv
module asram_wr_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && !busy && !done));

  // R2
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);

  // R8
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_data)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_strobes_off_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_cs_n && mem_we_n && busy));

  // R9
  no_early_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

bind asram_wr_ctrl asram_wr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mem_cs_n (mem_cs_n),
  .mem_we_n (mem_we_n),
  .mem_addr (mem_addr),
  .mem_data (mem_data)
);

// File: tb/asram_wr_ctrl_tb.sv
`timescale 1ns/1ps
module asram_wr_ctrl_tb;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] cfg_setup = '0;
  logic [CW-1:0] cfg_pulse = '0;
  logic [CW-1:0] cfg_hold = '0;
  logic [1:0]    cfg_wait_mode = 2'b00;
  logic          busy, done, mem_cs_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_wait_n = 1'b1;

  int errors = 0;
  int checks = 0;
  int seq = 0;

  asram_wr_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
    .cfg_hold(cfg_hold), .cfg_wait_mode(cfg_wait_mode), .busy(busy),
    .done(done), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_wait_n(mem_wait_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (seq %0d)", tag, act, exp, seq);
    end
  endtask

  // kind 0: wait high; 1: wait low until edge er; 2: wait low from the first ignored edge after the sample
  task automatic do_access(input int s, input int p, input int h, input logic [1:0] mode,
                           input int kind, input int er, input bit intrude, input string tag);
    int peff, wexp, csexp, doneexp;
    int we_low, cs_low, busy_cnt, done_cnt, done_at, bad_bus;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    seq++;
    peff = (p == 0) ? 1 : p;
    wexp = peff;
    if (mode == 2'b11 && kind == 1 && (er + 2 - s) > peff) wexp = er + 2 - s;
    csexp = s + wexp + h;
    doneexp = csexp;
    a = AW'(16'h1000 + seq * 7);
    d = DW'(seq * 13 + 5);
    we_low = 0; cs_low = 0; busy_cnt = 0; done_cnt = 0; done_at = -1; bad_bus = 0;
    mem_wait_n = (kind == 1) ? 1'b0 : 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    cfg_setup = CW'(s); cfg_pulse = CW'(p); cfg_hold = CW'(h); cfg_wait_mode = mode;
    if (kind == 1) mem_wait_n = (er <= 0);
    if (kind == 2) mem_wait_n = !(s + peff - 1 <= 0);
    @(posedge clk);
    for (int e = 0; e < doneexp + 4; e++) begin
      @(negedge clk);
      if (!mem_we_n) we_low++;
      if (!mem_cs_n) begin
        cs_low++;
        if (mem_addr != a || mem_data != d) bad_bus++;
      end
      if (busy) busy_cnt++;
      if (done) begin done_cnt++; done_at = e; end
      if (intrude && e + 1 <= doneexp) begin
        req_valid = 1'b1; req_addr = ~a; req_data = ~d;
        cfg_setup = CW'(0); cfg_pulse = CW'(1); cfg_hold = CW'(0);
      end else begin
        req_valid = 1'b0;
      end
      if (kind == 1) mem_wait_n = (e + 1 >= er);
      if (kind == 2) mem_wait_n = !(e + 1 >= s + peff - 1);
    end
    mem_wait_n = 1'b1;
    chk(we_low == wexp, {tag, " we_n low width"}, we_low, wexp);
    chk(cs_low == csexp, {tag, " R2 cs_n low width"}, cs_low, csexp);
    chk(done_cnt == 1, "R7 done pulse count", done_cnt, 1);
    chk(done_at == doneexp, "R7 done position", done_at, doneexp);
    chk(busy_cnt == doneexp + 1, "R7 busy span", busy_cnt, doneexp + 1);
    chk(bad_bus == 0, "R8 address/data during access", bad_bus, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    chk(mem_cs_n && mem_we_n && !busy && !done, "R1 outputs in reset",
        {mem_cs_n, mem_we_n, busy, done}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && !busy && !done, "R1 outputs after reset",
        {mem_cs_n, mem_we_n, busy, done}, 4'b1100);

    // R2 R3: fixed length over setup/pulse/hold sweep, wait idle
    for (int s = 0; s <= 2; s++)
      for (int p = 0; p <= 3; p++)
        for (int h = 0; h <= 2; h++)
          do_access(s, p, h, 2'b11, 0, 0, 1'b0, "R2 R3 sweep");

    // R4 R5: release edge sweep in ready mode
    for (int s = 0; s <= 2; s++)
      for (int p = 1; p <= 3; p++)
        for (int er = 0; er <= s + p + 4; er++)
          do_access(s, p, 1, 2'b11, 1, er, 1'b0, "R4 R5 release sweep");

    // R5: wait asserted after the sample point
    for (int s = 0; s <= 2; s++)
      for (int p = 1; p <= 3; p++)
        do_access(s, p, 2, 2'b11, 2, 0, 1'b0, "R5 late wait");

    // R6: non-ready modes ignore wait
    for (int m = 0; m <= 2; m++)
      for (int er = 0; er <= 8; er += 2)
        do_access(1, 2, 1, 2'(m), 1, er, 1'b0, "R6 mode ignore");

    // R9: requests while busy
    do_access(2, 3, 2, 2'b11, 0, 0, 1'b1, "R9 busy request");
    do_access(0, 1, 0, 2'b11, 1, 6, 1'b1, "R9 busy request in wait");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule